// File: doc/BRIEF.md
# Strap-Sampled Mode Register with External Interrupt Lines

This block serves a set of shared active-low input pads in two roles. While the chip is held in reset, the pads are boot-mode straps. On the first clock edge that sees reset released, their synchronized levels are written into a mode register, and that value then stays fixed until the next reset. After that, each pad becomes a maskable external interrupt request. Software picks, line by line, whether a request follows the pad level or is latched on a falling edge.

Every pad passes through a multi-flop synchronizer before any logic uses it. A line in edge mode keeps its request in a pending flag until a clear strobe removes it. A line in level mode raises its request for as long as its pad is low. No request is produced while reset is held or on the edge that captures the straps, so a strap tied low is never mistaken for an interrupt. A separate wake output lets pad 0 pull the core out of its stop state, whatever the other pads or the enable mask are doing.

Top module: `strap_irq_ctrl`

## Requirements
- R1: A change on a pad reaches the level-mode request output exactly two clock edges after the pad changes, so the synchronizer is two flops deep.
- R2: On the first clock edge with `rst_n` high after reset, `boot_mode[i]` takes the synchronized level of `pad_n[i]`, where a high pad gives 1. It then keeps that value while reset stays released, whatever the pads do.
- R3: `irq_req` is all zero while `rst_n` is low and on the capture edge. Requests can appear from the next edge onward. A pad that is already low at release does not count as a falling edge.
- R4: When `trig_fall[i]`=0 (level mode) and `irq_en[i]`=1, `irq_req[i]` is 1 exactly while the synchronized pad is low.
- R5: When `trig_fall[i]`=1 (edge mode), a synchronized high-to-low transition sets a pending flag. It shows on `irq_req[i]` three edges after the pad falls and stays set after the pad returns high.
- R6: A one-cycle `pend_clr[i]` pulse clears that line's pending flag on the next edge. If a new falling edge arrives in the same cycle, the set wins.
- R7: With `irq_en[i]`=0, `irq_req[i]` is 0, but a falling edge still sets the pending flag. The request shows as soon as the enable returns.
- R8: `wake` is 1 when `stop_mode`=1, reset has completed and synchronized pad 0 is low. It does not depend on the other pads or on `irq_en`, and it is 0 when `stop_mode`=0.
- R9: While a line is in level mode, its pending flag is held clear, so an edge captured earlier is discarded.
- R10: A later reset clears all pending flags and recaptures the mode from the pads present at its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pad_n | input | NUM_LINES | Shared active-low strap / interrupt pads |
| trig_fall | input | NUM_LINES | Per-line trigger select: 1 = falling edge, 0 = level |
| irq_en | input | NUM_LINES | Per-line request enable |
| pend_clr | input | NUM_LINES | Per-line pending clear strobe |
| stop_mode | input | 1 | Core is in its stop/standby state |
| boot_mode | output | NUM_LINES | Mode value captured at reset release |
| irq_req | output | NUM_LINES | Masked interrupt requests |
| wake | output | 1 | Request to leave stop, driven from pad 0 |

## Verification
The embedded properties check the per-cycle rules on every edge after reset. These rules are: a synchronized falling edge in edge mode must set pending, a clear must take effect unless a new edge arrives, level mode must drop pending, a masked line must stay silent, the mode register must not move once armed, and wake must follow stop and pad 0. Other behaviour can only be shown by the bench's scenarios. That covers the exact latency of two or three edges from pad to request, the strap values actually landing in the mode register, the silent capture edge, strap-low pads not being taken as edges, and a second reset recapturing a new mode.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;

    // Trigger selection per interrupt line
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    // Smallest synchronizer depth that is accepted
    localparam int SYNC_MIN = 2;

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync
    import strap_irq_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int DEPTH = (STAGES < SYNC_MIN) ? SYNC_MIN : STAGES;

    // The flops run freely, reset or not, so the straps settle before release
    logic [WIDTH-1:0] stage_d [DEPTH];
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < DEPTH; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/sirq_mode_latch.sv
module sirq_mode_latch #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pads_s,
    output logic [WIDTH-1:0] mode,
    output logic             arm
);
    typedef struct packed {
        logic             in_rst;
        logic             arm;
        logic [WIDTH-1:0] mode;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.in_rst = 1'b1;
            st_d.arm    = 1'b0;
        end else if (st_q.in_rst) begin
            // capture edge: straps go in, requests stay off for this cycle
            st_d.mode   = pads_s;
            st_d.in_rst = 1'b0;
            st_d.arm    = 1'b0;
        end else begin
            st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign arm  = st_q.arm;

    // once armed, the captured mode must not move
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.arm |=> $stable(st_q.mode));

    // arming only ever follows a capture edge
    assert_arm_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_rst) |=> !st_q.arm);

endmodule

// File: rtl/sirq_line.sv
module sirq_line
    import strap_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arm,
    input  logic  lvl,      // synchronized pad, active low
    input  trig_e trig,
    input  logic  en,
    input  logic  clr,
    output logic  req
);
    typedef struct packed {
        logic prev;
        logic pend;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     fall;

    always_comb begin
        fall     = st_q.prev & ~lvl;
        st_d     = st_q;
        st_d.prev = lvl;    // tracks through reset so held-low straps are no edge
        if (!rst_n || trig == TRIG_LEVEL) begin
            st_d.pend = 1'b0;
        end else if (arm && fall) begin
            st_d.pend = 1'b1;
        end else if (clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req = en & arm & ((trig == TRIG_FALL) ? st_q.pend : ~lvl);

    assert_fall_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && trig == TRIG_FALL && st_q.prev && !lvl) |=> st_q.pend);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(st_q.prev && !lvl)) |=> !st_q.pend);

    assert_level_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_LEVEL) |=> !st_q.pend);

    assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req);

    assert_unarmed_quiet_R3: assert property (@(posedge clk)
        !arm |-> !req);

endmodule

// File: rtl/strap_irq_ctrl.sv
module strap_irq_ctrl
    import strap_irq_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pad_n,
    input  logic [NUM_LINES-1:0] trig_fall,
    input  logic [NUM_LINES-1:0] irq_en,
    input  logic [NUM_LINES-1:0] pend_clr,
    input  logic                 stop_mode,
    output logic [NUM_LINES-1:0] boot_mode,
    output logic [NUM_LINES-1:0] irq_req,
    output logic                 wake
);
    localparam int WAKE_LINE = 0;

    logic [NUM_LINES-1:0] pads_s;
    logic                 arm;

    sirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pad_n),
        .dout (pads_s)
    );

    sirq_mode_latch #(.WIDTH(NUM_LINES)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .pads_s (pads_s),
        .mode   (boot_mode),
        .arm    (arm)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        sirq_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm),
            .lvl   (pads_s[i]),
            .trig  (trig_e'(trig_fall[i])),
            .en    (irq_en[i]),
            .clr   (pend_clr[i]),
            .req   (irq_req[i])
        );
    end

    // wake ignores the mask and the other pads
    assign wake = stop_mode & arm & ~pads_s[WAKE_LINE];

    assert_wake_on_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && stop_mode && !pads_s[WAKE_LINE]) |-> wake);

    assert_no_wake_running_R8: assert property (@(posedge clk)
        !stop_mode |-> !wake);

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !trig_fall[0] && irq_en[0]) |-> (irq_req[0] == !pads_s[0]));

endmodule

// File: tb/tb_strap_irq_ctrl.sv
module tb_strap_irq_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pad_n, trig_fall, irq_en, pend_clr;
    logic         stop_mode;
    logic [N-1:0] boot_mode, irq_req;
    logic         wake;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int           due;
        bit           c_req, c_mode, c_wake;
        logic [N-1:0] req, mode;
        logic         wk;
        string        tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    strap_irq_ctrl #(.NUM_LINES(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .pad_n(pad_n), .trig_fall(trig_fall),
        .irq_en(irq_en), .pend_clr(pend_clr), .stop_mode(stop_mode),
        .boot_mode(boot_mode), .irq_req(irq_req), .wake(wake)
    );

    // driver side: queue an expectation d edges ahead
    task automatic expect_out(input int d, input bit cr, input logic [N-1:0] r,
                              input bit cm, input logic [N-1:0] m,
                              input bit cw, input logic w, input string tag);
        item_t it;
        it.due = cyc + d; it.c_req = cr; it.req = r; it.c_mode = cm; it.mode = m;
        it.c_wake = cw; it.wk = w; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor side: sample mid-phase after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            for (int k = sb.size() - 1; k >= 0; k--) begin
                if (sb[k].due == cyc) begin
                    if (sb[k].c_req) begin
                        n_chk++;
                        if (irq_req !== sb[k].req) begin
                            n_fail++;
                            $display("FAIL %s irq_req act=%b exp=%b cyc=%0d", sb[k].tag, irq_req, sb[k].req, cyc);
                        end
                    end
                    if (sb[k].c_mode) begin
                        n_chk++;
                        if (boot_mode !== sb[k].mode) begin
                            n_fail++;
                            $display("FAIL %s boot_mode act=%b exp=%b cyc=%0d", sb[k].tag, boot_mode, sb[k].mode, cyc);
                        end
                    end
                    if (sb[k].c_wake) begin
                        n_chk++;
                        if (wake !== sb[k].wk) begin
                            n_fail++;
                            $display("FAIL %s wake act=%b exp=%b cyc=%0d", sb[k].tag, wake, sb[k].wk, cyc);
                        end
                    end
                    sb.delete(k);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pad_n = 4'b1010; trig_fall = 4'b0000; irq_en = 4'hF;
        pend_clr = 4'b0; stop_mode = 1'b1;
        step(5);
        // R3/R8: quiet in reset even with pad 0 low and stop set
        expect_out(1, 1, 4'b0000, 0, 'x, 1, 1'b0, "R3 reset quiet / R8 no wake in reset");
        step(1);
        rst_n = 1;
        expect_out(1, 1, 4'b0000, 1, 4'b1010, 0, 'x, "R2 capture / R3 capture edge silent");
        expect_out(2, 1, 4'b0101, 0, 'x, 1, 1'b1, "R4 level after arm / R8 wake");
        step(3);
        stop_mode = 0;
        expect_out(1, 0, 'x, 0, 'x, 1, 1'b0, "R8 wake off when running");
        step(1);
        pad_n = 4'hF;
        expect_out(1, 1, 4'b0101, 0, 'x, 0, 'x, "R1 not yet through");
        expect_out(2, 1, 4'b0000, 1, 4'b1010, 0, 'x, "R1 two-edge latency / R2 mode held");
        step(3);
        // R5 edge mode on line 1
        trig_fall = 4'b0010; pad_n = 4'b1101;
        expect_out(2, 1, 4'b0000, 0, 'x, 0, 'x, "R5 edge not yet latched");
        expect_out(3, 1, 4'b0010, 0, 'x, 0, 'x, "R5 pending shown");
        step(4);
        pad_n = 4'hF;
        expect_out(3, 1, 4'b0010, 0, 'x, 0, 'x, "R5 pending held after pad high");
        step(4);
        pend_clr = 4'b0010;
        expect_out(1, 1, 4'b0000, 0, 'x, 0, 'x, "R6 clear strobe");
        step(1);
        pend_clr = 4'b0;
        step(1);
        // R7 masked edge
        irq_en = 4'b1101; pad_n = 4'b1101;
        step(2);
        pad_n = 4'hF;
        expect_out(2, 1, 4'b0000, 0, 'x, 0, 'x, "R7 masked line silent");
        step(4);
        irq_en = 4'hF;
        expect_out(1, 1, 4'b0010, 0, 'x, 0, 'x, "R7 pending kept while masked");
        step(2);
        // R9 level mode discards pending
        trig_fall = 4'b0000;
        expect_out(1, 1, 4'b0000, 0, 'x, 0, 'x, "R9 level with pad high");
        step(2);
        trig_fall = 4'b0010;
        expect_out(1, 1, 4'b0000, 0, 'x, 0, 'x, "R9 pending discarded");
        step(2);
        // R8 wake independent of mask and other pads
        stop_mode = 1; irq_en = 4'h0; pad_n = 4'b1110;
        expect_out(2, 1, 4'b0000, 0, 'x, 1, 1'b1, "R8 wake with mask off / R7 masked");
        step(3);
        pad_n = 4'b0001;
        expect_out(2, 0, 'x, 0, 'x, 1, 1'b0, "R8 other pads do not wake");
        step(3);
        // R10: leave a pending edge on line 1, then reset with new straps
        stop_mode = 0; irq_en = 4'hF; pad_n = 4'hF;
        step(3);
        pad_n = 4'b1101;
        expect_out(3, 1, 4'b0010, 0, 'x, 0, 'x, "R10 pending before reset");
        step(4);
        rst_n = 0; pad_n = 4'b0101;
        expect_out(1, 1, 4'b0000, 0, 'x, 0, 'x, "R10 reset clears requests");
        step(4);
        rst_n = 1;
        expect_out(1, 1, 4'b0000, 1, 4'b0101, 0, 'x, "R10 new mode captured");
        expect_out(2, 1, 4'b1000, 0, 'x, 0, 'x, "R3 strap low is no edge / R10 pending gone");
        step(5);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover act=%0d exp=0", sb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule